// File: doc/BRIEF.md
# Snoop-Aware Cache Tag Port Arbiter

This block owns the tag and coherence-state storage of a small direct-mapped cache and shares its one tag port among three sources: line fills coming back from the memory side, the local load/store unit, and the bus snoop logic. Each cycle at most one of them reads or updates the array. The losing sources are either not granted (processor) or told to stall (snoop). A stalled snoop keeps presenting itself until it is accepted.

Lines use a three-state ownership scheme: Invalid, Shared and Modified. An exclusive fill installs a line as Modified and announces a retry to the load/store unit. From that fill until the retried store reaches the tag port, every snoop is held off. This keeps a remote ownership request from invalidating the freshly owned line before the local store has used it. Without that window, two processors fighting for one line could take it from each other forever.

Processor lookups return hit, miss or upgrade one cycle after the grant. Snoop lookups return hit and flush one cycle after acceptance, and their state changes are applied at that same edge.

Top module: `snoop_tag_arbiter`

## Requirements
- R1: After reset every line is Invalid, so any processor access misses; all response outputs are low.
- R2: A fill writes the line's tag and sets it to Modified when `fill_excl` is 1 or Shared when 0; `cpu_retry` pulses in the cycle after the fill.
- R3: A granted processor load gives `cpu_rsp_hit` when the tag matches and the line is Shared or Modified. A tag mismatch or an Invalid line gives `cpu_rsp_miss`.
- R4: A granted processor store to a matching Modified line gives `cpu_rsp_hit` and leaves the line Modified.
- R5: A granted processor store to a matching Shared line gives `cpu_rsp_upgrade`. A store to a missing or Invalid line gives `cpu_rsp_miss`. Neither store changes the line's state.
- R6: An accepted ownership snoop (`snp_own`=1) that matches a valid line gives `snp_rsp_hit` and moves the line to Invalid. If the line was Modified, it also gives `snp_rsp_flush`.
- R7: An accepted read snoop (`snp_own`=0) moves a matching Modified line to Shared and gives `snp_rsp_flush`. A matching Shared line stays Shared with no flush.
- R8: A snoop whose tag does not match, or whose line is Invalid, gives no hit and no flush and leaves the stored line unchanged.
- R9: Priority is fill over processor over snoop. `cpu_gnt` is low while `fill_valid` is high. `snp_acc` is low and `snp_stall` is high for a requested snoop whenever a fill or a processor request is present.
- R10: After an exclusive fill, every snoop is stalled until a granted processor store to the same full address. After that store, snoops are accepted again.
- R11: A stalled snoop that stays presented is accepted in a later cycle, and its state change takes effect then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fill writes a line this cycle |
| fill_excl | input | 1 | Fill grants ownership (Modified) |
| fill_addr | input | ADDR_W | Fill line address {tag, index} |
| cpu_req | input | 1 | Load/store unit requests the tag port |
| cpu_we | input | 1 | Request is a store |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_gnt | output | 1 | Processor owns the tag port this cycle |
| cpu_rsp_valid | output | 1 | Processor response valid |
| cpu_rsp_hit | output | 1 | Access completed |
| cpu_rsp_miss | output | 1 | Line absent, request a fill |
| cpu_rsp_upgrade | output | 1 | Store to Shared line, request ownership |
| cpu_retry | output | 1 | Replay the store after a fill |
| snp_req | input | 1 | Snoop presents a bus transaction |
| snp_own | input | 1 | Remote ownership request (else read) |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_acc | output | 1 | Snoop uses the tag port this cycle |
| snp_stall | output | 1 | Snoop held off, present again |
| snp_rsp_valid | output | 1 | Snoop response valid |
| snp_rsp_hit | output | 1 | Snoop matched a valid line |
| snp_rsp_flush | output | 1 | Line was Modified, supply data |

## Verification
The assertions assume that the bus side keeps a stalled snoop presented with the same address and kind in the next cycle, and that the remaining inputs are free. The directed stimulus honours this. Each snoop is re-driven unchanged after a stall until `snp_acc` rises. Fills, processor requests and snoops are otherwise combined freely within one cycle to hit every priority case.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_MOD = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_FILL = 2'b01,
    SRC_CPU  = 2'b10,
    SRC_SNP  = 2'b11
  } port_src_e;

  // state a valid, matching line takes after an accepted snoop
  function automatic line_st_e snoop_next(input line_st_e cur, input logic own);
    if (own)            return ST_INV;
    if (cur == ST_MOD)  return ST_SHR;
    return cur;
  endfunction

  function automatic logic needs_flush(input line_st_e cur);
    return cur == ST_MOD;
  endfunction

  function automatic line_st_e fill_state(input logic excl);
    return excl ? ST_MOD : ST_SHR;
  endfunction
endpackage

// File: rtl/stp_tag_store.sv
module stp_tag_store
  import stp_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_e         rd_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_state
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tag_q[i] <= '0;
          st_q[i]  <= ST_INV;
        end else if (wr_en && wr_idx == IDX_W'(i)) begin
          tag_q[i] <= wr_tag;
          st_q[i]  <= wr_state;
        end
      end
    end
  endgenerate

  assign rd_tag   = tag_q[rd_idx];
  assign rd_state = st_q[rd_idx];

  assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_state != line_st_e'(2'b11)));
endmodule

// File: rtl/stp_port_arbiter.sv
module stp_port_arbiter
  import stp_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic              fill_excl,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              snp_req,
  output port_src_e         src,
  output logic              snp_stall,
  output logic              retry_pend
);
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_q;
  logic              store_retired;

  always_comb begin
    if (fill_valid)                    src = SRC_FILL;
    else if (cpu_req)                  src = SRC_CPU;
    else if (snp_req && !pend_q)       src = SRC_SNP;
    else                               src = SRC_NONE;
  end

  assign snp_stall     = snp_req && (src != SRC_SNP);
  assign store_retired = (src == SRC_CPU) && cpu_we && (cpu_addr == pend_addr_q);
  assign retry_pend    = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (fill_valid && fill_excl) begin
      pend_q      <= 1'b1;
      pend_addr_q <= fill_addr;
    end else if (store_retired) begin
      pend_q      <= 1'b0;
    end
  end

  assert_proc_beats_snoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req || fill_valid) && snp_req |-> snp_stall);

  assert_window_blocks_snoop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (src != SRC_SNP));

  assert_window_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store_retired && !fill_valid |=> !pend_q);
endmodule

// File: rtl/stp_line_ctrl.sv
module stp_line_ctrl
  import stp_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  port_src_e        src,
  input  logic             fill_excl,
  input  logic             cpu_we,
  input  logic             snp_own,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] rd_tag,
  input  line_st_e         rd_state,
  output logic             wr_en,
  output logic [TAG_W-1:0] wr_tag,
  output line_st_e         wr_state,
  output logic             cpu_hit,
  output logic             cpu_miss,
  output logic             cpu_upg,
  output logic             snp_hit,
  output logic             snp_flush
);
  logic match;
  assign match = (rd_state != ST_INV) && (rd_tag == req_tag);

  always_comb begin
    wr_en     = 1'b0;
    wr_tag    = rd_tag;
    wr_state  = rd_state;
    cpu_hit   = 1'b0;
    cpu_miss  = 1'b0;
    cpu_upg   = 1'b0;
    snp_hit   = 1'b0;
    snp_flush = 1'b0;
    unique case (src)
      SRC_FILL: begin
        wr_en    = 1'b1;
        wr_tag   = req_tag;
        wr_state = fill_state(fill_excl);
      end
      SRC_CPU: begin
        cpu_hit  = match && (!cpu_we || rd_state == ST_MOD);
        cpu_miss = !match;
        cpu_upg  = match && cpu_we && (rd_state == ST_SHR);
      end
      SRC_SNP: begin
        snp_hit   = match;
        snp_flush = match && needs_flush(rd_state);
        wr_en     = match;
        wr_state  = snoop_next(rd_state, snp_own);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/snoop_tag_arbiter.sv
module snoop_tag_arbiter
  import stp_pkg::*;
#(
  parameter  int TAG_W  = 6,
  parameter  int IDX_W  = 3,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic              fill_excl,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_gnt,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic              cpu_rsp_miss,
  output logic              cpu_rsp_upgrade,
  output logic              cpu_retry,
  input  logic              snp_req,
  input  logic              snp_own,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_acc,
  output logic              snp_stall,
  output logic              snp_rsp_valid,
  output logic              snp_rsp_hit,
  output logic              snp_rsp_flush
);
  port_src_e        src;
  logic             retry_pend;
  logic [ADDR_W-1:0] sel_addr;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  line_st_e         rd_state, wr_state;
  logic             wr_en;
  logic             hit_c, miss_c, upg_c, shit_c, flush_c;

  stp_port_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_excl(fill_excl), .fill_addr(fill_addr),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .snp_req(snp_req), .src(src), .snp_stall(snp_stall), .retry_pend(retry_pend)
  );

  always_comb begin
    unique case (src)
      SRC_FILL: sel_addr = fill_addr;
      SRC_CPU:  sel_addr = cpu_addr;
      default:  sel_addr = snp_addr;
    endcase
  end

  stp_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(sel_addr[IDX_W-1:0]), .rd_tag(rd_tag), .rd_state(rd_state),
    .wr_en(wr_en), .wr_idx(sel_addr[IDX_W-1:0]), .wr_tag(wr_tag), .wr_state(wr_state)
  );

  stp_line_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .src(src), .fill_excl(fill_excl), .cpu_we(cpu_we), .snp_own(snp_own),
    .req_tag(sel_addr[ADDR_W-1:IDX_W]), .rd_tag(rd_tag), .rd_state(rd_state),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_state(wr_state),
    .cpu_hit(hit_c), .cpu_miss(miss_c), .cpu_upg(upg_c),
    .snp_hit(shit_c), .snp_flush(flush_c)
  );

  assign cpu_gnt = (src == SRC_CPU);
  assign snp_acc = (src == SRC_SNP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rsp_valid   <= 1'b0;
      cpu_rsp_hit     <= 1'b0;
      cpu_rsp_miss    <= 1'b0;
      cpu_rsp_upgrade <= 1'b0;
      cpu_retry       <= 1'b0;
      snp_rsp_valid   <= 1'b0;
      snp_rsp_hit     <= 1'b0;
      snp_rsp_flush   <= 1'b0;
    end else begin
      cpu_rsp_valid   <= cpu_gnt;
      cpu_rsp_hit     <= hit_c;
      cpu_rsp_miss    <= miss_c;
      cpu_rsp_upgrade <= upg_c;
      cpu_retry       <= (src == SRC_FILL);
      snp_rsp_valid   <= snp_acc;
      snp_rsp_hit     <= shit_c;
      snp_rsp_flush   <= flush_c;
    end
  end

  assert_one_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_valid, cpu_gnt, snp_acc}));

  assert_retry_follows_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> cpu_retry);

  assert_store_on_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_gnt && cpu_we && rd_state == ST_MOD && rd_tag == cpu_addr[ADDR_W-1:IDX_W]
    |=> cpu_rsp_hit && !cpu_rsp_upgrade && !cpu_rsp_miss);

  assert_own_snoop_kills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_acc && snp_own && shit_c |-> wr_en && wr_state == ST_INV);

  assert_dirty_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_acc && rd_state == ST_MOD && rd_tag == snp_addr[ADDR_W-1:IDX_W] |=> snp_rsp_flush);

  assert_stall_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_stall |=> snp_req && $stable(snp_addr) && $stable(snp_own));
endmodule

// File: tb/test_snoop_tag_arbiter.sv
module test_snoop_tag_arbiter;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 0, fill_excl = 0, cpu_req = 0, cpu_we = 0, snp_req = 0, snp_own = 0;
  logic [AW-1:0] fill_addr = '0, cpu_addr = '0, snp_addr = '0;
  logic cpu_gnt, cpu_rsp_valid, cpu_rsp_hit, cpu_rsp_miss, cpu_rsp_upgrade, cpu_retry;
  logic snp_acc, snp_stall, snp_rsp_valid, snp_rsp_hit, snp_rsp_flush;

  int total = 0;
  int bad = 0;

  // captured per step
  logic c_gnt, c_acc, c_stall;
  logic r_cv, r_hit, r_miss, r_upg, r_retry, r_sv, r_shit, r_flush;

  localparam logic [AW-1:0] LA  = 9'h015; // tag 2 idx 5
  localparam logic [AW-1:0] LA2 = 9'h025; // tag 4 idx 5
  localparam logic [AW-1:0] LB  = 9'h0A3; // tag 20 idx 3
  localparam logic [AW-1:0] LC  = 9'h1F7; // tag 62 idx 7

  snoop_tag_arbiter i_snoop_tag_arbiter (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_excl(fill_excl), .fill_addr(fill_addr),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_gnt(cpu_gnt), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit),
    .cpu_rsp_miss(cpu_rsp_miss), .cpu_rsp_upgrade(cpu_rsp_upgrade), .cpu_retry(cpu_retry),
    .snp_req(snp_req), .snp_own(snp_own), .snp_addr(snp_addr),
    .snp_acc(snp_acc), .snp_stall(snp_stall), .snp_rsp_valid(snp_rsp_valid),
    .snp_rsp_hit(snp_rsp_hit), .snp_rsp_flush(snp_rsp_flush)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one cycle starting at a falling edge; returns at the next falling edge
  task automatic step(input logic fv, input logic fx, input logic [AW-1:0] fa,
                      input logic cr, input logic cw, input logic [AW-1:0] ca,
                      input logic sr, input logic so, input logic [AW-1:0] sa);
    fill_valid = fv; fill_excl = fx; fill_addr = fa;
    cpu_req = cr; cpu_we = cw; cpu_addr = ca;
    snp_req = sr; snp_own = so; snp_addr = sa;
    #1;
    c_gnt = cpu_gnt; c_acc = snp_acc; c_stall = snp_stall;
    @(negedge clk);
    r_cv = cpu_rsp_valid; r_hit = cpu_rsp_hit; r_miss = cpu_rsp_miss; r_upg = cpu_rsp_upgrade;
    r_retry = cpu_retry; r_sv = snp_rsp_valid; r_shit = snp_rsp_hit; r_flush = snp_rsp_flush;
    fill_valid = 0; fill_excl = 0; cpu_req = 0; cpu_we = 0; snp_req = 0; snp_own = 0;
  endtask

  task automatic do_fill(input logic x, input logic [AW-1:0] a);
    step(1, x, a, 0, 0, '0, 0, 0, '0);
  endtask
  task automatic do_cpu(input logic w, input logic [AW-1:0] a);
    step(0, 0, '0, 1, w, a, 0, 0, '0);
  endtask
  task automatic do_snp(input logic o, input logic [AW-1:0] a);
    step(0, 0, '0, 0, 0, '0, 1, o, a);
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid after reset", cpu_rsp_valid, 0);
    chk("R1", "retry after reset", cpu_retry, 0);
    chk("R1", "snoop rsp after reset", snp_rsp_valid, 0);
    do_cpu(0, LA);
    chk("R1", "load miss after reset", r_miss, 1);
    chk("R1", "load hit after reset", r_hit, 0);
    do_cpu(1, LB);
    chk("R1", "store miss after reset", r_miss, 1);
  endtask

  task automatic t_shared_fill;
    do_fill(0, LA);
    chk("R2", "retry after shared fill", r_retry, 1);
    do_cpu(0, LA);
    chk("R3", "load hit shared", r_hit, 1);
    chk("R3", "load rsp valid", r_cv, 1);
    chk("R2", "retry single pulse", r_retry, 0);
    do_cpu(1, LA);
    chk("R5", "store on shared upgrade", r_upg, 1);
    chk("R5", "store on shared not hit", r_hit, 0);
    do_cpu(1, LA);
    chk("R5", "shared stays shared", r_upg, 1);
    do_cpu(0, LA2);
    chk("R3", "tag mismatch miss", r_miss, 1);
    do_cpu(1, LC);
    chk("R5", "store to absent line miss", r_miss, 1);
    chk("R5", "store to absent no upgrade", r_upg, 0);
    do_cpu(0, LC);
    chk("R5", "missed store left line invalid", r_miss, 1);
  endtask

  task automatic t_retry_window;
    do_fill(1, LB);
    chk("R2", "retry after exclusive fill", r_retry, 1);
    do_snp(1, LB);
    chk("R10", "snoop stalled in retry window", c_stall, 1);
    chk("R10", "snoop not accepted in window", c_acc, 0);
    step(0, 0, '0, 1, 1, LB, 1, 1, LB);
    chk("R9", "cpu granted over snoop", c_gnt, 1);
    chk("R9", "snoop stalled by cpu", c_stall, 1);
    chk("R4", "retried store hits", r_hit, 1);
    chk("R4", "retried store no upgrade", r_upg, 0);
    do_snp(1, LB);
    chk("R11", "held snoop accepted", c_acc, 1);
    chk("R6", "own snoop hit", r_shit, 1);
    chk("R6", "own snoop on modified flush", r_flush, 1);
    do_cpu(0, LB);
    chk("R6", "line invalid after own snoop", r_miss, 1);
  endtask

  task automatic t_snoop_read;
    do_fill(1, LA);
    do_cpu(1, LA);
    chk("R4", "store on owned hit", r_hit, 1);
    do_cpu(1, LA);
    chk("R4", "line still modified", r_hit, 1);
    do_snp(0, LA);
    chk("R10", "window closed, snoop accepted", c_acc, 1);
    chk("R7", "read snoop hit", r_shit, 1);
    chk("R7", "read snoop modified flush", r_flush, 1);
    do_cpu(1, LA);
    chk("R7", "modified demoted to shared", r_upg, 1);
    do_snp(0, LA);
    chk("R7", "read snoop shared hit", r_shit, 1);
    chk("R7", "read snoop shared no flush", r_flush, 0);
    do_cpu(0, LA);
    chk("R7", "shared still valid", r_hit, 1);
  endtask

  task automatic t_snoop_absent;
    do_snp(1, LA2);
    chk("R8", "mismatched snoop no hit", r_shit, 0);
    chk("R8", "mismatched snoop no flush", r_flush, 0);
    chk("R8", "mismatched snoop rsp valid", r_sv, 1);
    do_cpu(0, LA);
    chk("R8", "line untouched by mismatch", r_hit, 1);
    do_snp(0, LC);
    chk("R8", "invalid line snoop no hit", r_shit, 0);
  endtask

  task automatic t_priority;
    step(1, 0, LC, 1, 0, LA, 1, 1, LA);
    chk("R9", "cpu not granted under fill", c_gnt, 0);
    chk("R9", "snoop stalled under fill", c_stall, 1);
    chk("R9", "no cpu rsp under fill", r_cv, 0);
    chk("R9", "no snoop rsp under fill", r_sv, 0);
    step(0, 0, '0, 1, 0, LC, 1, 1, LA);
    chk("R9", "cpu load over snoop", c_gnt, 1);
    chk("R2", "shared fill installed line", r_hit, 1);
    do_snp(1, LA);
    chk("R11", "held snoop finally accepted", c_acc, 1);
    chk("R11", "held snoop took effect", r_shit, 1);
    do_cpu(0, LA);
    chk("R6", "shared line invalidated", r_miss, 1);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shared_fill();
    t_retry_window();
    t_snoop_read();
    t_snoop_absent();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule